// File: doc/BRIEF.md
# Byte-Serial Program-Memory Port

This block makes a window of ordinary paged RAM look like a byte-wide, self-advancing serial program memory. The CPU sees four byte ports: read data, write data, read pointer and write pointer. Behind them sits a 16-bit address pointer, and every data access turns into a request to a fixed 64 KB region of the paged RAM, pages 0x38 to 0x3F. The RAM is a plain synchronous byte memory outside the block, with one cycle of read latency.

The pointer is loaded and read back one byte at a time through a shift scheme, so the CPU always talks to the pointer's high byte. The region offset equals the raw pointer value. The pointer counts straight through 8 KB boundaries. The block keeps the byte at the pointer prefetched, so a data read is answered in the cycle it is presented. After every accepted access the block refetches, and a further access is held off with a wait signal until the new byte is in place. The port works only in compatibility mode. In native mode it stays silent.

Top module: `seqrom_port`

## Requirements
- R1: After reset the pointer is 0x0000. Once the first prefetch completes, a data read returns region byte 0.
- R2: A data read (CPU address 0x9800, cpu_we=0) returns the region byte at the pointer and advances the pointer by one.
- R3: A data write (CPU address 0x9C00, cpu_we=1) stores the byte at region offset equal to the pointer and then advances the pointer by one.
- R4: A pointer write (CPU address 0x9C02, cpu_we=1) moves the old high byte to the low byte and puts the written byte in the high byte. The first pointer write of a pair does not advance the pointer.
- R5: A pointer write that directly follows another pointer write performs the same shift and then advances the pointer by one. The next pointer write counts as a first write again.
- R6: A pointer read (CPU address 0x9802, cpu_we=0) returns the high byte and then copies the low byte into the high byte. The low byte is unchanged and the pointer does not advance.
- R7: The pointer is a plain 16-bit counter. 0x1FFF is followed by 0x2000, and 0xFFFF is followed by 0x0000.
- R8: With compat_mode low, accesses to the ports assert no wait, return 0, issue no memory write and leave the pointer unchanged.
- R9: After an accepted access, cpu_wait is high for the next two cycles while a port is addressed. A held access is accepted in the third cycle.
- R10: Every memory request addresses region base 0x70000 (page 0x38 × 8 KB) ORed with the 16-bit pointer on the 21-bit bus.
- R11: A data access or a pointer read makes the next pointer write count as a first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| compat_mode | input | 1 | 1 enables the port, 0 makes it inert |
| cpu_sel | input | 1 | CPU access strobe, held until cpu_wait is low |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | Read byte, valid in the accepting cycle |
| cpu_wait | output | 1 | Access held off while a refetch is in flight |
| mem_req | output | 1 | RAM request |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 21 | RAM byte address |
| mem_wdata | output | 8 | RAM write byte |
| mem_rdata | input | 8 | RAM read byte, one cycle after the request |

## Verification
The hardest situation to reach is the pointer-write pairing rule. It is visible only through the pointer value that later data reads land on, and it depends on the history of the previous accesses. The stimulus therefore sets up a single pointer write, breaks the pair with a data read, and writes again. The following data read then tells a missed reset of the pairing from a correct one by a one-off change in the returned byte. The RAM contents follow an address function that is not symmetric in its two bytes, so wrap at 0x1FFF and wrap at 0xFFFF each return a byte that differs from the correct one. A behavioural model tracks pointer, pairing, prefetch and wait on every clock.

// File: rtl/seqrom_pkg.sv
package seqrom_pkg;
   typedef enum logic [2:0] {
      PORT_NONE    = 3'd0,
      PORT_RD_DATA = 3'd1,
      PORT_RD_PTR  = 3'd2,
      PORT_WR_DATA = 3'd3,
      PORT_WR_PTR  = 3'd4
   } port_e;

   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_REQ  = 2'd1,
      FS_LOAD = 2'd2
   } fetch_e;

   localparam int NUM_PORTS = 4;
endpackage

// File: rtl/seqrom_decode.sv
module seqrom_decode
   import seqrom_pkg::*;
#(
   parameter int             AW          = 16,
   parameter logic [AW-1:0]  RD_DATA_AT  = 16'h9800,
   parameter logic [AW-1:0]  RD_PTR_AT   = 16'h9802,
   parameter logic [AW-1:0]  WR_DATA_AT  = 16'h9C00,
   parameter logic [AW-1:0]  WR_PTR_AT   = 16'h9C02,
   parameter logic [AW-1:0]  MATCH_MASK  = 16'hFFFF
) (
   input  logic          sel,
   input  logic          we,
   input  logic [AW-1:0] addr,
   output port_e         port
);
   logic [NUM_PORTS-1:0] hit;

   for (genvar i = 0; i < NUM_PORTS; i++) begin : g_cmp
      localparam logic [AW-1:0] AT = (i == 0) ? RD_DATA_AT :
                                     (i == 1) ? RD_PTR_AT  :
                                     (i == 2) ? WR_DATA_AT : WR_PTR_AT;
      localparam bit IS_WR = (i >= 2);
      assign hit[i] = sel && (we == IS_WR) && ((addr & MATCH_MASK) == (AT & MATCH_MASK));
   end

   if (((RD_DATA_AT & MATCH_MASK) == (RD_PTR_AT & MATCH_MASK)) ||
       ((WR_DATA_AT & MATCH_MASK) == (WR_PTR_AT & MATCH_MASK))) begin : g_bad_map
      $error("seqrom_decode: two ports of one direction share an address");
   end

   always_comb begin
      port = PORT_NONE;
      if      (hit[0]) port = PORT_RD_DATA;
      else if (hit[1]) port = PORT_RD_PTR;
      else if (hit[2]) port = PORT_WR_DATA;
      else if (hit[3]) port = PORT_WR_PTR;
   end
endmodule

// File: rtl/seqrom_ptr.sv
module seqrom_ptr
   import seqrom_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int PTR_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  port_e             port,
   input  logic [DATA_W-1:0] wdata,
   output logic [PTR_W-1:0]  ptr
);
   logic             second_byte;
   logic [PTR_W-1:0] shifted_in;
   logic [PTR_W-1:0] ptr_next;
   logic             second_next;

   assign shifted_in = {wdata, ptr[PTR_W-1:DATA_W]};

   always_comb begin
      ptr_next    = ptr;
      second_next = second_byte;
      if (take) begin
         unique case (port)
            PORT_RD_DATA, PORT_WR_DATA: begin
               ptr_next    = ptr + PTR_W'(1);
               second_next = 1'b0;
            end
            PORT_RD_PTR: begin
               ptr_next    = {ptr[DATA_W-1:0], ptr[DATA_W-1:0]};
               second_next = 1'b0;
            end
            PORT_WR_PTR: begin
               ptr_next    = second_byte ? shifted_in + PTR_W'(1) : shifted_in;
               second_next = ~second_byte;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr         <= '0;
         second_byte <= 1'b0;
      end else begin
         ptr         <= ptr_next;
         second_byte <= second_next;
      end
   end
endmodule

// File: rtl/seqrom_fetch.sv
module seqrom_fetch
   import seqrom_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              fetch_req,
   output logic              busy,
   output logic [DATA_W-1:0] pf_byte
);
   fetch_e state;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= FS_REQ;
         pf_byte <= '0;
      end else begin
         unique case (state)
            FS_IDLE: if (start) state <= FS_REQ;
            FS_REQ:  state <= FS_LOAD;
            FS_LOAD: begin
               pf_byte <= mem_rdata;
               state   <= FS_IDLE;
            end
            default: state <= FS_IDLE;
         endcase
      end
   end

   assign fetch_req = (state == FS_REQ);
   assign busy      = (state != FS_IDLE);
endmodule

// File: rtl/seqrom_port.sv
module seqrom_port
   import seqrom_pkg::*;
#(
   parameter int            DATA_W        = 8,
   parameter int            CPU_AW        = 16,
   parameter int            PHYS_W        = 21,
   parameter int            PAGE_W        = 13,
   parameter int            REGION_PAGE   = 'h38,
   parameter logic [15:0]   RD_DATA_AT    = 16'h9800,
   parameter logic [15:0]   RD_PTR_AT     = 16'h9802,
   parameter logic [15:0]   WR_DATA_AT    = 16'h9C00,
   parameter logic [15:0]   WR_PTR_AT     = 16'h9C02,
   parameter logic [15:0]   MATCH_MASK    = 16'hFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              compat_mode,
   input  logic              cpu_sel,
   input  logic              cpu_we,
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_wait,
   output logic              mem_req,
   output logic              mem_we,
   output logic [PHYS_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int PTR_W = 2 * DATA_W;
   localparam logic [PHYS_W-1:0] REGION_BASE = PHYS_W'(REGION_PAGE) << PAGE_W;

   if (PHYS_W < PTR_W) begin : g_bad_width
      $error("seqrom_port: physical bus narrower than the pointer");
   end
   if ((REGION_BASE & ((PHYS_W'(1) << PTR_W) - PHYS_W'(1))) != '0) begin : g_bad_align
      $error("seqrom_port: region base not aligned to the pointer span");
   end

   port_e             port;
   logic              busy;
   logic              fetch_req;
   logic              acc_valid;
   logic [PTR_W-1:0]  ptr;
   logic [DATA_W-1:0] pf_byte;

   seqrom_decode #(
      .AW(CPU_AW), .RD_DATA_AT(RD_DATA_AT), .RD_PTR_AT(RD_PTR_AT),
      .WR_DATA_AT(WR_DATA_AT), .WR_PTR_AT(WR_PTR_AT), .MATCH_MASK(MATCH_MASK)
   ) u_decode (
      .sel  (cpu_sel && compat_mode),
      .we   (cpu_we),
      .addr (cpu_addr),
      .port (port)
   );

   assign acc_valid = (port != PORT_NONE) && !busy;
   assign cpu_wait  = (port != PORT_NONE) && busy;

   seqrom_ptr #(.DATA_W(DATA_W)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (acc_valid),
      .port  (port),
      .wdata (cpu_wdata),
      .ptr   (ptr)
   );

   seqrom_fetch #(.DATA_W(DATA_W)) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (acc_valid),
      .mem_rdata (mem_rdata),
      .fetch_req (fetch_req),
      .busy      (busy),
      .pf_byte   (pf_byte)
   );

   always_comb begin
      cpu_rdata = '0;
      if (acc_valid && port == PORT_RD_DATA) cpu_rdata = pf_byte;
      else if (acc_valid && port == PORT_RD_PTR) cpu_rdata = ptr[PTR_W-1:DATA_W];
   end

   assign mem_we    = acc_valid && (port == PORT_WR_DATA);
   assign mem_req   = fetch_req || mem_we;
   assign mem_addr  = REGION_BASE | PHYS_W'(ptr);
   assign mem_wdata = cpu_wdata;
endmodule

// File: rtl/seqrom_port_chk.sv
module seqrom_port_chk
   import seqrom_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int PHYS_W      = 21,
   parameter int PAGE_W      = 13,
   parameter int REGION_PAGE = 'h38,
   localparam int PTR_W = 2 * DATA_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              compat_mode,
   input logic              cpu_sel,
   input logic              cpu_wait,
   input logic              mem_req,
   input logic              mem_we,
   input logic [PHYS_W-1:0] mem_addr,
   input logic              acc_valid,
   input port_e             port,
   input logic [PTR_W-1:0]  ptr
);
   localparam logic [PHYS_W-1:0] BASE = PHYS_W'(REGION_PAGE) << PAGE_W;

   p_region_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[PHYS_W-1:PTR_W] == BASE[PHYS_W-1:PTR_W]));

   p_refetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> (mem_req && !mem_we));

   p_data_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && (port == PORT_RD_DATA || port == PORT_WR_DATA))
      |=> (ptr == $past(ptr) + PTR_W'(1)));

   p_ptr_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && port == PORT_RD_PTR)
      |=> (ptr[PTR_W-1:DATA_W] == $past(ptr[DATA_W-1:0]) &&
           ptr[DATA_W-1:0] == $past(ptr[DATA_W-1:0])));

   p_write_at_ptr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && port == PORT_WR_DATA) |-> (mem_req && mem_we && mem_addr[PTR_W-1:0] == ptr));

   p_native_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_sel && !compat_mode) |-> (!cpu_wait && !mem_we));

   p_native_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !compat_mode |=> $stable(ptr));
endmodule

bind seqrom_port seqrom_port_chk #(
   .DATA_W(DATA_W), .PHYS_W(PHYS_W), .PAGE_W(PAGE_W), .REGION_PAGE(REGION_PAGE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .compat_mode(compat_mode), .cpu_sel(cpu_sel),
   .cpu_wait(cpu_wait), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
   .acc_valid(acc_valid), .port(port), .ptr(ptr)
);

// File: tb/seqrom_port_bench.sv
module seqrom_port_bench;
   localparam logic [15:0] A_RD_DATA = 16'h9800;
   localparam logic [15:0] A_RD_PTR  = 16'h9802;
   localparam logic [15:0] A_WR_DATA = 16'h9C00;
   localparam logic [15:0] A_WR_PTR  = 16'h9C02;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        compat_mode = 1'b1;
   logic        cpu_sel = 1'b0;
   logic        cpu_we = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic [7:0]  cpu_rdata;
   logic        cpu_wait;
   logic        mem_req;
   logic        mem_we;
   logic [20:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   seqrom_port u_seqrom_port (
      .clk(clk), .rst_n(rst_n), .compat_mode(compat_mode), .cpu_sel(cpu_sel),
      .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .cpu_wait(cpu_wait), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // background RAM contents: not symmetric in the two address bytes
   function automatic logic [7:0] bg(input logic [15:0] off);
      return off[7:0] + 8'(off[15:8] * 3) + 8'h5A;
   endfunction

   logic [7:0] wmem [logic [15:0]];

   function automatic logic [7:0] ram_val(input logic [15:0] off);
      return wmem.exists(off) ? wmem[off] : bg(off);
   endfunction

   function automatic int port_of(input logic [15:0] a, input logic we);
      if (!we && a == A_RD_DATA) return 1;
      if (!we && a == A_RD_PTR)  return 2;
      if (we  && a == A_WR_DATA) return 3;
      if (we  && a == A_WR_PTR)  return 4;
      return 0;
   endfunction

   // RAM with one cycle of read latency
   always @(posedge clk) begin
      if (mem_req) begin
         chk(mem_addr[20:16] == 5'h07, "R10 region", int'(mem_addr), 32'h70000);
         if (mem_we) wmem[mem_addr[15:0]] = mem_wdata;
         else mem_rdata <= ram_val(mem_addr[15:0]);
      end
   end

   // behavioural reference model
   logic [15:0] m_ptr;
   bit          m_pair;
   int          m_cnt;
   logic [7:0]  m_pf, m_pend;

   always @(posedge clk) begin
      int p;
      p = port_of(cpu_addr, cpu_we);
      if (!rst_n) begin
         m_ptr = '0; m_pair = 0; m_cnt = 2; m_pend = ram_val(16'h0000); m_pf = '0;
      end else if (m_cnt != 0) begin
         m_cnt--;
         if (m_cnt == 0) m_pf = m_pend;
      end else if (cpu_sel && compat_mode && p != 0) begin
         case (p)
            1, 3: begin m_ptr = m_ptr + 16'd1; m_pair = 0; end
            2:    begin m_ptr = {m_ptr[7:0], m_ptr[7:0]}; m_pair = 0; end
            default: begin
               m_ptr  = m_pair ? {cpu_wdata, m_ptr[15:8]} + 16'd1 : {cpu_wdata, m_ptr[15:8]};
               m_pair = !m_pair;
            end
         endcase
         m_cnt  = 2;
         m_pend = ram_val(m_ptr);
      end
   end

   always @(negedge clk) begin
      int p;
      bit exp_wait;
      if (rst_n) begin
         p = port_of(cpu_addr, cpu_we);
         exp_wait = cpu_sel && compat_mode && p != 0 && m_cnt != 0;
         chk(cpu_wait === exp_wait, "R9 wait", int'(cpu_wait), int'(exp_wait));
         if (cpu_sel && compat_mode && m_cnt == 0 && p == 1)
            chk(cpu_rdata === m_pf, "R2 model data", int'(cpu_rdata), int'(m_pf));
         if (cpu_sel && compat_mode && m_cnt == 0 && p == 2)
            chk(cpu_rdata === m_ptr[15:8], "R6 model ptr", int'(cpu_rdata), int'(m_ptr[15:8]));
         if (cpu_sel && !compat_mode)
            chk(cpu_rdata === 8'h00 && !(mem_req && mem_we), "R8 native", int'(cpu_rdata), 0);
      end
   end

   // one access, held while cpu_wait; returns read byte and wait count
   task automatic access(input logic [15:0] a, input logic we, input logic [7:0] wd,
                         output logic [7:0] rd, output int waits);
      cpu_sel = 1'b1; cpu_addr = a; cpu_we = we; cpu_wdata = wd;
      waits = 0;
      forever begin
         @(negedge clk);
         if (!cpu_wait) begin rd = cpu_rdata; break; end
         waits++;
      end
      @(posedge clk); #1;
      cpu_sel = 1'b0;
   endtask

   task automatic rd_data(input logic [7:0] exp, input string tag);
      logic [7:0] r; int w;
      access(A_RD_DATA, 1'b0, 8'h00, r, w);
      chk(r === exp, tag, int'(r), int'(exp));
   endtask

   task automatic rd_ptr(input logic [7:0] exp, input string tag);
      logic [7:0] r; int w;
      access(A_RD_PTR, 1'b0, 8'h00, r, w);
      chk(r === exp, tag, int'(r), int'(exp));
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      logic [7:0] r; int w;
      access(a, 1'b1, d, r, w);
   endtask

   bit done = 0;

   initial begin
      logic [7:0] r;
      int w;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: first read after reset, waits for the initial prefetch
      access(A_RD_DATA, 1'b0, 8'h00, r, w);
      chk(r === bg(16'h0000), "R1 first byte", int'(r), int'(bg(16'h0000)));
      chk(w == 2, "R1 reset prefetch wait", w, 2);
      // R2 and R9: back-to-back reads
      access(A_RD_DATA, 1'b0, 8'h00, r, w);
      chk(r === bg(16'h0001), "R2 sequential", int'(r), int'(bg(16'h0001)));
      chk(w == 2, "R9 held two cycles", w, 2);
      rd_data(bg(16'h0002), "R2 sequential");
      // R6: pointer is 0x0003
      rd_ptr(8'h00, "R6 high byte");
      rd_ptr(8'h03, "R6 low copied up");
      // R4: single pointer write, no step; pointer 0x0303 -> 0x1203
      wr(A_WR_PTR, 8'h12);
      rd_ptr(8'h12, "R4 shift in");
      rd_ptr(8'h03, "R4 old high moved down");
      // R5, R7: pair gives {1F,FE}+1 = 0x1FFF, then no 8 KB wrap
      wr(A_WR_PTR, 8'hFE);
      wr(A_WR_PTR, 8'h1F);
      rd_data(bg(16'h1FFF), "R5 pair steps pointer");
      rd_data(bg(16'h2000), "R7 no segment wrap");
      // R3: write at 0x0041 and read it back
      wr(A_WR_PTR, 8'h40);
      wr(A_WR_PTR, 8'h00);
      wr(A_WR_DATA, 8'hC3);
      rd_data(bg(16'h0042), "R3 pointer stepped after write");
      wr(A_WR_PTR, 8'h40);
      wr(A_WR_PTR, 8'h00);
      rd_data(8'hC3, "R3 stored at pointer");
      // R11: single pointer write, then data read, then another pointer write
      wr(A_WR_PTR, 8'h77);
      rd_data(bg(16'h7700), "R11 single write then read");
      wr(A_WR_PTR, 8'h88);
      rd_data(bg(16'h8877), "R11 pairing restarted");
      // R7: 16-bit wrap
      wr(A_WR_PTR, 8'hFE);
      wr(A_WR_PTR, 8'hFF);
      rd_data(bg(16'hFFFF), "R7 top byte");
      rd_data(bg(16'h0000), "R7 wrap to zero");
      // R8: native mode, pointer is 0x0001
      compat_mode = 1'b0;
      access(A_RD_DATA, 1'b0, 8'h00, r, w);
      chk(r === 8'h00 && w == 0, "R8 read ignored", int'(r), 0);
      wr(A_WR_PTR, 8'h55);
      wr(A_WR_PTR, 8'h66);
      wr(A_WR_DATA, 8'h99);
      access(A_RD_PTR, 1'b0, 8'h00, r, w);
      chk(r === 8'h00 && w == 0, "R8 pointer read ignored", int'(r), 0);
      compat_mode = 1'b1;
      rd_ptr(8'h00, "R8 pointer kept");
      rd_data(bg(16'h0101), "R8 pointer kept");
      wr(A_WR_PTR, 8'h01);
      wr(A_WR_PTR, 8'h00);
      rd_data(bg(16'h0002), "R8 no memory write");
      done = 1;
      repeat (3) @(posedge clk);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule